// File: doc/BRIEF.md
# Indirect Command and Status Register Block for a Network Controller

This block holds the host-visible control state of a network controller. The host reaches it through three ports: an index port, a data port and a reset pulse. It first writes a register index into the index port. Later data-port writes go to the register that index selects, and the read bus shows that register. The main register is a 16-bit command word. Its bits do different jobs: some are computed summary bits, some are sticky event flags that clear when a one is written to them, some are one-shot commands, and some are plain read/write controls. A second register holds a byte-swap enable.

Event pulses from the receive, transmit, memory and initialization logic set the sticky flags. The block drives an interrupt line. It also drives a one-cycle transmit-demand strobe for the transmit engine. A stop command or the reset pulse returns the block to its stopped, quiet state.

Top module: `csrIndirectRegs`

## Requirements
- R1: The index port holds a 7-bit index. A data write goes to the index that was held before that cycle. Index 0 is the command word and index 3 is the mode register. Every other index reads as zero and ignores writes. The read bus shows the selected register in the same cycle.
- R2: Bit 15 of the command word reads as the OR of bits 14, 13, 12 and 11. Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8.
- R3: Bits 14 to 8 are sticky flags. From bit 14 down they are: babble, collision, missed frame, memory error, receive done, transmit done and init done. An event pulse sets its flag at the next edge. Writing a one to a flag clears it. Writing a zero leaves it unchanged. When an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: Bits 3 and 2 always read as zero. Bits 15, 7, 5 and 4 cannot be written.
- R5: Writing the command word with bit 2 (stop) set does the following at the next edge: it clears bits 14 to 0, it ignores any start or init bits in the same write, and it drops any event pulses in that cycle.
- R6: irqOut is high exactly when bit 7 (interrupt summary) and bit 6 (interrupt enable) are both set.
- R7: When stop is clear, a command write loads bit 6 (interrupt enable), bit 1 (start) and bit 0 (init) from the written data.
- R8: A command write with bit 3 set and stop clear, made while start was already set before the write, gives txDemand high for exactly the cycle after the write. Without start, no pulse is produced.
- R9: Bit 5 (receiver on) and bit 4 (transmitter on) copy the start bit with a delay of one cycle. Stop clears them at the same edge that it clears start.
- R10: Bit 2 of the mode register is read/write and drives swapEn. The other bits of the mode register read as zero.
- R11: The reset pulse, or a low rstN, has the same effect as stop. It also clears the index and the byte-swap bit. It overrides any index or data write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portReset | input | 1 | Synchronous reset-port pulse |
| addrWe | input | 1 | Index port write strobe |
| addrIn | input | 7 | Register index to select |
| dataWe | input | 1 | Data port write strobe |
| dataIn | input | 16 | Data port write value |
| rdData | output | 16 | Selected register value |
| evBabble | input | 1 | Transmit babble event |
| evCollide | input | 1 | Collision error event |
| evMissed | input | 1 | Missed frame event |
| evMemErr | input | 1 | Memory error event |
| evRxDone | input | 1 | Receive done event |
| evTxDone | input | 1 | Transmit done event |
| evInitDone | input | 1 | Initialization done event |
| irqOut | output | 1 | Interrupt request |
| txDemand | output | 1 | One-cycle transmit-demand strobe |
| swapEn | output | 1 | Byte-swap enable |

## Verification
Two kinds of operation can land on the same flag in the same cycle. One is a host write-one clear, and the other is a hardware event pulse. The same is true of a stop command and a start, init or event arriving together. The bench provokes both collisions with directed writes that raise the event pulse on the very cycle of the clear or the stop. Random traffic then repeats them many times with events on every cycle. A reference model in the bench applies the written priorities: the event beats the clear, and stop beats everything. The bench compares the read bus, irqOut and txDemand cycle by cycle.

// File: rtl/csrRegPkg.sv
package csrRegPkg;
  localparam int WORD_W = 16;
  localparam int FLAG_N = 7;

  localparam int B_ERR  = 15;
  localparam int B_FTOP = 14;
  localparam int B_FBOT = 8;
  localparam int B_INTR = 7;
  localparam int B_IENA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_TDMD = 3;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;
  localparam int B_SWAP = 2;

  // control-to-datapath strobes
  typedef struct packed {
    logic cmdWr;
    logic modeWr;
    logic stopHit;
    logic tdmdHit;
    logic selCmd;
    logic selMode;
    logic clrAll;
  } csrStrobe_t;
endpackage

// File: rtl/csrAccessCtrl.sv
module csrAccessCtrl
  import csrRegPkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int CMD_IDX  = 0,
  parameter int MODE_IDX = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portReset,
  input  logic             addrWe,
  input  logic [IDX_W-1:0] addrIn,
  input  logic             dataWe,
  input  logic             stopBit,
  input  logic             tdmdBit,
  input  logic             curStrt,
  output logic [IDX_W-1:0] curIdx,
  output csrStrobe_t       strb
);
  localparam logic [IDX_W-1:0] CmdIdx  = IDX_W'(CMD_IDX);
  localparam logic [IDX_W-1:0] ModeIdx = IDX_W'(MODE_IDX);

  logic [IDX_W-1:0] idxQ;
  logic hitCmd, hitMode, cmdWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          idxQ <= '0;
    else if (portReset) idxQ <= '0;
    else if (addrWe)    idxQ <= addrIn;
  end

  assign curIdx  = idxQ;
  assign hitCmd  = (idxQ == CmdIdx);
  assign hitMode = (idxQ == ModeIdx);
  assign cmdWr   = dataWe & hitCmd & ~portReset;

  always_comb begin
    strb.selCmd  = hitCmd;
    strb.selMode = hitMode;
    strb.cmdWr   = cmdWr;
    strb.modeWr  = dataWe & hitMode & ~portReset;
    strb.stopHit = portReset | (cmdWr & stopBit);
    strb.tdmdHit = cmdWr & tdmdBit & ~stopBit & curStrt;
    strb.clrAll  = portReset;
  end
endmodule

// File: rtl/csrDatapath.sv
module csrDatapath
  import csrRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strb,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [FLAG_N-1:0] evtIn,
  output logic [WORD_W-1:0] cmdWord,
  output logic [WORD_W-1:0] rdData,
  output logic              strtQ,
  output logic              irqOut,
  output logic              txDemand,
  output logic              swapEn
);
  logic [FLAG_N-1:0] flagQ;
  logic ienaQ, initQ, rxOnQ, txOnQ, tdmdQ, swapQ;
  logic errSum, intSum;
  logic [WORD_W-1:0] modeWord;
  logic unusedDataBits;

  assign unusedDataBits = ^{dataIn[B_ERR], dataIn[B_INTR], dataIn[B_RXON],
                            dataIn[B_TXON], dataIn[WORD_W-1:0] & 16'h0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0; ienaQ <= 1'b0; strtQ <= 1'b0; initQ <= 1'b0;
      rxOnQ <= 1'b0; txOnQ <= 1'b0; tdmdQ <= 1'b0; swapQ <= 1'b0;
    end else if (strb.stopHit) begin
      flagQ <= '0; ienaQ <= 1'b0; strtQ <= 1'b0; initQ <= 1'b0;
      rxOnQ <= 1'b0; txOnQ <= 1'b0; tdmdQ <= 1'b0;
      if (strb.clrAll) swapQ <= 1'b0;
    end else begin
      if (strb.cmdWr) begin
        flagQ <= (flagQ & ~dataIn[B_FTOP:B_FBOT]) | evtIn;
        ienaQ <= dataIn[B_IENA];
        strtQ <= dataIn[B_STRT];
        initQ <= dataIn[B_INIT];
      end else begin
        flagQ <= flagQ | evtIn;
      end
      rxOnQ <= strtQ;
      txOnQ <= strtQ;
      tdmdQ <= strb.tdmdHit;
      if (strb.modeWr) swapQ <= dataIn[B_SWAP];
    end
  end

  // flag order: babble, collide, missed, memErr, rxDone, txDone, initDone
  assign errSum = |flagQ[6:3];
  assign intSum = flagQ[6] | (|flagQ[4:0]);

  always_comb begin
    cmdWord                  = '0;
    cmdWord[B_ERR]           = errSum;
    cmdWord[B_FTOP:B_FBOT]   = flagQ;
    cmdWord[B_INTR]          = intSum;
    cmdWord[B_IENA]          = ienaQ;
    cmdWord[B_RXON]          = rxOnQ;
    cmdWord[B_TXON]          = txOnQ;
    cmdWord[B_STRT]          = strtQ;
    cmdWord[B_INIT]          = initQ;
    modeWord                 = '0;
    modeWord[B_SWAP]         = swapQ;
  end

  assign rdData   = strb.selCmd ? cmdWord : (strb.selMode ? modeWord : '0);
  assign irqOut   = intSum & ienaQ;
  assign txDemand = tdmdQ;
  assign swapEn   = swapQ;
endmodule

// File: rtl/csrIndirectRegs.sv
module csrIndirectRegs
  import csrRegPkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int CMD_IDX  = 0,
  parameter int MODE_IDX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portReset,
  input  logic              addrWe,
  input  logic [IDX_W-1:0]  addrIn,
  input  logic              dataWe,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] rdData,
  input  logic              evBabble,
  input  logic              evCollide,
  input  logic              evMissed,
  input  logic              evMemErr,
  input  logic              evRxDone,
  input  logic              evTxDone,
  input  logic              evInitDone,
  output logic              irqOut,
  output logic              txDemand,
  output logic              swapEn
);
  csrStrobe_t        strb;
  logic [IDX_W-1:0]  curIdx;
  logic [WORD_W-1:0] cmdWord;
  logic              strtQ;
  logic [FLAG_N-1:0] evtVec;
  logic              unusedIdx;

  assign evtVec    = {evBabble, evCollide, evMissed, evMemErr, evRxDone, evTxDone, evInitDone};
  assign unusedIdx = ^curIdx;

  csrAccessCtrl #(.IDX_W(IDX_W), .CMD_IDX(CMD_IDX), .MODE_IDX(MODE_IDX)) uCtrl (
    .clk(clk), .rstN(rstN), .portReset(portReset), .addrWe(addrWe), .addrIn(addrIn),
    .dataWe(dataWe), .stopBit(dataIn[B_STOP]), .tdmdBit(dataIn[B_TDMD]),
    .curStrt(strtQ), .curIdx(curIdx), .strb(strb)
  );

  csrDatapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .evtIn(evtVec),
    .cmdWord(cmdWord), .rdData(rdData), .strtQ(strtQ), .irqOut(irqOut),
    .txDemand(txDemand), .swapEn(swapEn)
  );
endmodule

// File: rtl/csrRegChecker.sv
module csrRegChecker
  import csrRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input csrStrobe_t        strb,
  input logic [WORD_W-1:0] cmdWord,
  input logic              irqOut,
  input logic              txDemand
);
  // R3: a set flag with no clear and no stop stays set
  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWord[B_FTOP] && !strb.cmdWr && !strb.stopHit) |=> cmdWord[B_FTOP]);

  // R5: stop leaves bits 14..0 clear
  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopHit |=> (cmdWord[B_FTOP:0] == '0));

  // R6: interrupt line needs enable and summary
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (cmdWord[B_IENA] && cmdWord[B_INTR]));

  // R8: strobe only follows an accepted demand
  a_r8_tdmd_source: assert property (@(posedge clk) disable iff (!rstN)
    txDemand |-> $past(strb.tdmdHit));

  // R8: a demand is accepted only while started
  a_r8_tdmd_started: assert property (@(posedge clk) disable iff (!rstN)
    strb.tdmdHit |-> cmdWord[B_STRT]);

  // R9: receiver and transmitter follow start
  a_r9_on_follows: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWord[B_STRT] && !strb.stopHit) |=> (cmdWord[B_RXON] && cmdWord[B_TXON]));
endmodule

bind csrIndirectRegs csrRegChecker uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .cmdWord(cmdWord),
  .irqOut(irqOut), .txDemand(txDemand)
);

// File: tb/csrIndirectRegs_test.sv
module csrIndirectRegs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portReset = 1'b0, addrWe = 1'b0, dataWe = 1'b0;
  logic [6:0]  addrIn = '0;
  logic [15:0] dataIn = '0;
  logic [6:0]  ev = '0;
  logic [15:0] rdData;
  logic irqOut, txDemand, swapEn;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // model state
  logic [6:0] mAddr = '0, mFlags = '0;
  logic mIena = 0, mStrt = 0, mInit = 0, mRx = 0, mTx = 0, mTxd = 0, mSwap = 0;

  always #2 clk = ~clk;

  csrIndirectRegs uut (
    .clk(clk), .rstN(rstN), .portReset(portReset), .addrWe(addrWe), .addrIn(addrIn),
    .dataWe(dataWe), .dataIn(dataIn), .rdData(rdData),
    .evBabble(ev[6]), .evCollide(ev[5]), .evMissed(ev[4]), .evMemErr(ev[3]),
    .evRxDone(ev[2]), .evTxDone(ev[1]), .evInitDone(ev[0]),
    .irqOut(irqOut), .txDemand(txDemand), .swapEn(swapEn)
  );

  function automatic logic [15:0] expRd();
    logic err, intr;
    err  = |mFlags[6:3];
    intr = mFlags[6] | (|mFlags[4:0]);
    if (mAddr == 7'd0) return {err, mFlags, intr, mIena, mRx, mTx, 2'b00, mStrt, mInit};
    if (mAddr == 7'd3) return {13'd0, mSwap, 2'b00};
    return 16'd0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "rdData", rdData, expRd());
    chk({tag, " R6"}, "irqOut", {15'd0, irqOut}, {15'd0, (mFlags[6] | (|mFlags[4:0])) & mIena});
    chk({tag, " R8"}, "txDemand", {15'd0, txDemand}, {15'd0, mTxd});
    chk({tag, " R10"}, "swapEn", {15'd0, swapEn}, {15'd0, mSwap});
  endtask

  // drive one cycle at negedge after checking the state left by the last edge
  task automatic step(input string tag, input logic pr, input logic aw, input logic [6:0] ai,
                      input logic dw, input logic [15:0] di, input logic [6:0] e);
    logic stopNow, cmdW, modeW;
    @(negedge clk);
    checkAll(tag);
    portReset = pr; addrWe = aw; addrIn = ai; dataWe = dw; dataIn = di; ev = e;
    cmdW    = dw && (mAddr == 7'd0) && !pr;
    modeW   = dw && (mAddr == 7'd3) && !pr;
    stopNow = pr || (cmdW && di[2]);
    if (stopNow) begin
      mFlags = '0; mIena = 0; mStrt = 0; mInit = 0; mRx = 0; mTx = 0; mTxd = 0;
      if (pr) begin mAddr = '0; mSwap = 0; end
      else if (aw) mAddr = ai;
    end else begin
      mTxd = cmdW && di[3] && mStrt;
      mRx = mStrt; mTx = mStrt;
      if (cmdW) begin
        mFlags = (mFlags & ~di[14:8]) | e;
        mIena = di[6]; mStrt = di[1]; mInit = di[0];
      end else mFlags = mFlags | e;
      if (modeW) mSwap = di[2];
      if (aw) mAddr = ai;
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 7'd0, 0, 16'd0, 7'd0);
  endtask

  initial begin
    void'($urandom(32'h1c5a_7e01));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R11 reset state
    idle("R11 reset");
    // R1 select command word, R7 enable + start
    step("R1", 0, 1, 7'd0, 0, 16'd0, 7'd0);
    step("R7", 0, 0, 7'd0, 1, 16'h0043, 7'd0);
    idle("R9 one cycle later");
    idle("R9");
    // R3 events set flags, R2 summaries, R6 interrupt
    step("R3", 0, 0, 7'd0, 0, 16'd0, 7'b1010101);
    idle("R2 R3 R6");
    // R3 write zero to flags keeps them (keep started/enabled)
    step("R3 zero write", 0, 0, 7'd0, 1, 16'h0043, 7'd0);
    idle("R3");
    // R3 clear collides with event on the same flag: event wins
    step("R3 clear+event", 0, 0, 7'd0, 1, 16'h7F43, 7'b1000000);
    idle("R3 event wins");
    // R8 demand while started
    step("R8 demand", 0, 0, 7'd0, 1, 16'h004B, 7'd0);
    idle("R8 pulse");
    idle("R8 pulse gone");
    // R5 stop with start and init, events in the same cycle dropped
    step("R5 stop", 0, 0, 7'd0, 1, 16'h0047, 7'b1111111);
    idle("R5 stopped");
    // R8 demand while stopped: no pulse
    step("R8 stopped demand", 0, 0, 7'd0, 1, 16'h0008, 7'd0);
    idle("R8 no pulse");
    // R4 read-only bits unwritable
    step("R4", 0, 0, 7'd0, 1, 16'h80B0, 7'd0);
    idle("R4");
    // R10 mode register
    step("R10", 0, 1, 7'd3, 0, 16'd0, 7'd0);
    step("R10 write", 0, 0, 7'd0, 1, 16'hFFFF, 7'd0);
    idle("R10 swap on");
    // R1 unused index reads zero, ignores writes
    step("R1", 0, 1, 7'd5, 0, 16'd0, 7'd0);
    step("R1 ignore", 0, 0, 7'd0, 1, 16'hFFFF, 7'd0);
    idle("R1 zero");
    // R11 reset port beats writes
    step("R11", 0, 1, 7'd0, 0, 16'd0, 7'd0);
    step("R11 arm", 0, 0, 7'd0, 1, 16'h0042, 7'd0);
    step("R11 pulse", 1, 1, 7'd3, 1, 16'h0043, 7'b0000111);
    idle("R11 after");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic pr, aw, dw;
      logic [6:0] ai, e;
      logic [15:0] di;
      int sel;
      pr  = ($urandom_range(63) == 0);
      aw  = ($urandom_range(3) == 0);
      dw  = ($urandom_range(1) == 0);
      sel = $urandom_range(3);
      ai  = (sel < 2) ? 7'd0 : (sel == 2 ? 7'd3 : 7'($urandom));
      di  = 16'($urandom);
      di[2] = ($urandom_range(15) == 0);
      if ($urandom_range(1) == 0) di[1] = 1'b1;
      for (int b = 0; b < 7; b++) e[b] = ($urandom_range(7) == 0);
      step("random R1 R2 R3 R4 R5 R7 R9 R11", pr, aw, ai, dw, di, e);
    end
    idle("final");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule